// File: doc/BRIEF.md
# Bus Activity Monitor Counter

This block watches a stream of activity pulses on a bus and turns them into a weighted count for each sampling period. Every pulse adds a programmed weight to a running count. A period tick closes the period, and the count of that period then feeds two mechanisms. The first is a shift-based exponential moving average. The second is a pair of run-length detectors. A detector flags an event once the raw count has stayed above the upper threshold, or below the lower threshold, for a programmed number of periods in a row. The moving average is also compared against its own high and low limits.

Software sets up the monitor through a small word-addressed register port. Through it, software enables the monitor, picks the averaging window and the run lengths, loads the thresholds and the weight, seeds the average, reads the average back, and clears the event flags. A single interrupt line is the OR of the flags whose enables are set. Frequency policy is left to the consumer of that interrupt and of the average.

Top module: `busmon_top`

## Requirements
- R1: After reset, every register reads zero, the average is zero, no event flag is set and `irq` is low.
- R2: While the monitor is enabled (control bit 31), each cycle with `act_event` high adds the weight register (offset 0x18) to the period count. The count saturates at all ones rather than wrapping.
- R3: A period closes on a `period_tick` cycle only when both the monitor enable (bit 31) and the periodic enable (bit 18) are set. Ticks are ignored otherwise, and activity is not counted while the monitor is disabled. An activity pulse in the closing cycle counts toward the new period.
- R4: At each period close, the average becomes avg + ((count − avg) >>> (K+1)), using arithmetic (floor) shifting. K is the 3-bit control field at bits 12:10.
- R5: A write to the seed register (offset 0x0C) loads the average directly. It wins over a period close in the same cycle. Offset 0x20 reads back the average.
- R6: A closed count strictly above the upper threshold (0x04) is a high breach. After Nhi+1 consecutive high breaches, status bit 31 is set, where Nhi is the 3-bit field at control bits 28:26. A non-breaching period resets the run, and the run restarts after each flag.
- R7: A closed count strictly below the lower threshold (0x08) is a low breach. After Nlo+1 consecutive low breaches, status bit 30 is set, where Nlo is the 3-bit field at control bits 25:23. The same reset and restart rules apply as for R6.
- R8: At each period close, status bit 29 is set if the new average is above the high limit (0x10), and status bit 28 is set if it is below the low limit (0x14).
- R9: Writing ones to the status register (0x24) clears the matching bits. A flag being set in the same cycle wins over its clear.
- R10: `irq` is high exactly when at least one of the following pairs has both its status bit and its control enable set: bit 31 with control bit 30, bit 30 with control bit 29, bit 29 with control bit 21, or bit 28 with control bit 20.
- R11: The control word and registers 0x04 to 0x18 read back as written, and unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW (6) | Byte offset of the register |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr`, combinational |
| act_event | input | 1 | One unit of bus activity in this cycle |
| period_tick | input | 1 | End of sampling period |
| irq | output | 1 | OR of the enabled status flags |

## Verification
The bench builds the block with its defaults: a 32-bit count, a 3-bit averaging constant and 3-bit run lengths. With these values a weight of 0xC000_0000 reaches count saturation in two pulses. They also allow averaging windows from 2 up to 256 periods and runs of one to eight periods, including the case where a run is interrupted and then restarts. Odd negative differences at a window of two expose the floor rounding of the average. Same-cycle collisions are driven on purpose: seed against tick, tick against activity, and clear against set.

// File: rtl/busmon_pkg.sv
package busmon_pkg;
  // register byte offsets
  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_UPPER  = 8'h04;
  localparam logic [7:0] OFS_LOWER  = 8'h08;
  localparam logic [7:0] OFS_SEED   = 8'h0C;
  localparam logic [7:0] OFS_AVG_HI = 8'h10;
  localparam logic [7:0] OFS_AVG_LO = 8'h14;
  localparam logic [7:0] OFS_WEIGHT = 8'h18;
  localparam logic [7:0] OFS_AVG    = 8'h20;
  localparam logic [7:0] OFS_STAT   = 8'h24;

  // control word bit positions
  localparam int CB_K_LSB      = 10;
  localparam int CB_PERIODIC   = 18;
  localparam int CB_IE_AVG_LO  = 20;
  localparam int CB_IE_AVG_HI  = 21;
  localparam int CB_NLO_LSB    = 23;
  localparam int CB_NHI_LSB    = 26;
  localparam int CB_IE_RUN_LO  = 29;
  localparam int CB_IE_RUN_HI  = 30;
  localparam int CB_ENABLE     = 31;

  // index of each flag inside the 4-bit status vector (status word bits 31:28)
  localparam int ST_AVG_LO = 0;
  localparam int ST_AVG_HI = 1;
  localparam int ST_RUN_LO = 2;
  localparam int ST_RUN_HI = 3;
  localparam int ST_BITS   = 4;

  typedef enum logic { DIR_HI = 1'b0, DIR_LO = 1'b1 } run_dir_e;
endpackage

// File: rtl/busmon_regs.sv
module busmon_regs
  import busmon_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wen,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [DW-1:0]      avg_in,
  input  logic [ST_BITS-1:0] stat_set,
  output logic [DW-1:0]      ctrl_o,
  output logic [DW-1:0]      upper_o,
  output logic [DW-1:0]      lower_o,
  output logic [DW-1:0]      avg_hi_o,
  output logic [DW-1:0]      avg_lo_o,
  output logic [DW-1:0]      weight_o,
  output logic               seed_load_o,
  output logic [DW-1:0]      seed_val_o,
  output logic [ST_BITS-1:0] stat_o
);
  logic [DW-1:0]      ctrl_q, upper_q, lower_q, seed_q, ahi_q, alo_q, weight_q;
  logic [ST_BITS-1:0] stat_q;
  logic [ST_BITS-1:0] stat_clr;

  function automatic logic hit_ofs(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == ofs[AW-1:0];
  endfunction

  assign stat_clr    = (wen && hit_ofs(addr, OFS_STAT)) ? wdata[DW-1 -: ST_BITS] : '0;
  assign seed_load_o = wen && hit_ofs(addr, OFS_SEED);
  assign seed_val_o  = wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      upper_q  <= '0;
      lower_q  <= '0;
      seed_q   <= '0;
      ahi_q    <= '0;
      alo_q    <= '0;
      weight_q <= '0;
      stat_q   <= '0;
    end else begin
      if (wen) begin
        if (hit_ofs(addr, OFS_CTRL))   ctrl_q   <= wdata;
        if (hit_ofs(addr, OFS_UPPER))  upper_q  <= wdata;
        if (hit_ofs(addr, OFS_LOWER))  lower_q  <= wdata;
        if (hit_ofs(addr, OFS_SEED))   seed_q   <= wdata;
        if (hit_ofs(addr, OFS_AVG_HI)) ahi_q    <= wdata;
        if (hit_ofs(addr, OFS_AVG_LO)) alo_q    <= wdata;
        if (hit_ofs(addr, OFS_WEIGHT)) weight_q <= wdata;
      end
      // set has priority over clear
      stat_q <= (stat_q & ~stat_clr) | stat_set;
    end
  end

  always_comb begin
    rdata = '0;
    if      (hit_ofs(addr, OFS_CTRL))   rdata = ctrl_q;
    else if (hit_ofs(addr, OFS_UPPER))  rdata = upper_q;
    else if (hit_ofs(addr, OFS_LOWER))  rdata = lower_q;
    else if (hit_ofs(addr, OFS_SEED))   rdata = seed_q;
    else if (hit_ofs(addr, OFS_AVG_HI)) rdata = ahi_q;
    else if (hit_ofs(addr, OFS_AVG_LO)) rdata = alo_q;
    else if (hit_ofs(addr, OFS_WEIGHT)) rdata = weight_q;
    else if (hit_ofs(addr, OFS_AVG))    rdata = avg_in;
    else if (hit_ofs(addr, OFS_STAT))   rdata[DW-1 -: ST_BITS] = stat_q;
  end

  assign ctrl_o   = ctrl_q;
  assign upper_o  = upper_q;
  assign lower_o  = lower_q;
  assign avg_hi_o = ahi_q;
  assign avg_lo_o = alo_q;
  assign weight_o = weight_q;
  assign stat_o   = stat_q;

  // a clear with no competing set leaves the cleared bits at zero
  assert_w1c_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr != '0 && stat_set == '0) |=> ((stat_q & $past(stat_clr)) == '0));
endmodule

// File: rtl/busmon_acc.sv
module busmon_acc #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic          ev,
  input  logic [DW-1:0] weight,
  input  logic          close,
  output logic [DW-1:0] acc
);
  logic [DW-1:0] acc_q, acc_d;

  function automatic logic [DW-1:0] sat_add(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [DW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[DW] ? {DW{1'b1}} : s[DW-1:0];
  endfunction

  always_comb begin
    acc_d = acc_q;
    if (!run_en)    acc_d = '0;
    else if (close) acc_d = ev ? weight : '0;
    else if (ev)    acc_d = sat_add(acc_q, weight);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // within a period the count only grows (saturation, no wrap)
  assert_count_no_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !close) |=> (acc_q >= $past(acc_q)));
  // disabled monitor holds an empty count
  assert_idle_count_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (acc_q == '0));
endmodule

// File: rtl/busmon_ema.sv
module busmon_ema #(
  parameter int DW = 32,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          step,
  input  logic [DW-1:0] sample,
  input  logic [KW-1:0] k,
  output logic [DW-1:0] avg,
  output logic [DW-1:0] avg_next
);
  logic [DW-1:0] avg_q;

  // avg + floor((sample - avg) / 2^(k+1))
  function automatic logic [DW-1:0] ema_step(input logic [DW-1:0] cur,
                                             input logic [DW-1:0] smp,
                                             input logic [KW-1:0] kk);
    logic signed [DW:0] d;
    logic [KW:0]        sh;
    sh = {1'b0, kk} + 1'b1;
    d  = $signed({1'b0, smp}) - $signed({1'b0, cur});
    d  = d >>> sh;
    return cur + d[DW-1:0];
  endfunction

  assign avg_next = ema_step(avg_q, sample, k);

  always_ff @(posedge clk) begin
    if (!rst_n)    avg_q <= '0;
    else if (load) avg_q <= load_val;
    else if (step) avg_q <= avg_next;
  end

  assign avg = avg_q;

  assert_seed_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (avg_q == $past(load_val)));
  // a filter step never leaves the interval spanned by old average and sample
  assert_step_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=>
      ((avg_q >= (($past(avg_q) < $past(sample)) ? $past(avg_q) : $past(sample))) &&
       (avg_q <= (($past(avg_q) > $past(sample)) ? $past(avg_q) : $past(sample)))));
endmodule

// File: rtl/busmon_run.sv
module busmon_run #(
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic          breach,
  input  logic [NW-1:0] num,
  output logic          hit
);
  logic [NW-1:0] run_q;

  // run_q counts earlier breaches in the current streak
  assign hit = step && breach && (run_q >= num);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  run_q <= '0;
    else if (step) begin
      if (!breach)      run_q <= '0;
      else if (hit)     run_q <= '0;
      else              run_q <= run_q + 1'b1;
    end
  end

  assert_quiet_period_resets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !breach) |=> (run_q == '0));
  assert_flag_after_hit_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (run_q == '0));
endmodule

// File: rtl/busmon_top.sv
module busmon_top
  import busmon_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6,
  parameter int KW = 3,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          act_event,
  input  logic          period_tick,
  output logic          irq
);
  localparam int NDIR = 2;

  logic [DW-1:0]      ctrl, upper, lower, avg_hi, avg_lo, weight, seed_val;
  logic [DW-1:0]      count, avg, avg_next;
  logic               seed_load;
  logic [ST_BITS-1:0] stat, stat_set, stat_ie;
  logic               mon_en, step;
  logic [KW-1:0]      k_val;
  logic [NDIR-1:0]    breach, hit;
  logic [NW-1:0]      run_num [NDIR];

  busmon_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .avg_in(avg), .stat_set(stat_set), .ctrl_o(ctrl),
    .upper_o(upper), .lower_o(lower), .avg_hi_o(avg_hi), .avg_lo_o(avg_lo),
    .weight_o(weight), .seed_load_o(seed_load), .seed_val_o(seed_val), .stat_o(stat)
  );

  assign mon_en = ctrl[CB_ENABLE];
  assign step   = mon_en && ctrl[CB_PERIODIC] && period_tick;
  assign k_val  = ctrl[CB_K_LSB +: KW];

  busmon_acc #(.DW(DW)) u_acc (
    .clk(clk), .rst_n(rst_n), .run_en(mon_en), .ev(act_event), .weight(weight),
    .close(step), .acc(count)
  );

  busmon_ema #(.DW(DW), .KW(KW)) u_ema (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .load_val(seed_val), .step(step),
    .sample(count), .k(k_val), .avg(avg), .avg_next(avg_next)
  );

  assign breach[DIR_HI]  = count > upper;
  assign breach[DIR_LO]  = count < lower;
  assign run_num[DIR_HI] = ctrl[CB_NHI_LSB +: NW];
  assign run_num[DIR_LO] = ctrl[CB_NLO_LSB +: NW];

  for (genvar g = 0; g < NDIR; g++) begin : g_run
    busmon_run #(.NW(NW)) u_run (
      .clk(clk), .rst_n(rst_n), .clr(!mon_en), .step(step), .breach(breach[g]),
      .num(run_num[g]), .hit(hit[g])
    );
  end

  always_comb begin
    stat_set            = '0;
    stat_set[ST_RUN_HI] = hit[DIR_HI];
    stat_set[ST_RUN_LO] = hit[DIR_LO];
    stat_set[ST_AVG_HI] = step && !seed_load && (avg_next > avg_hi);
    stat_set[ST_AVG_LO] = step && !seed_load && (avg_next < avg_lo);
  end

  always_comb begin
    stat_ie            = '0;
    stat_ie[ST_RUN_HI] = ctrl[CB_IE_RUN_HI];
    stat_ie[ST_RUN_LO] = ctrl[CB_IE_RUN_LO];
    stat_ie[ST_AVG_HI] = ctrl[CB_IE_AVG_HI];
    stat_ie[ST_AVG_LO] = ctrl[CB_IE_AVG_LO];
  end

  assign irq = |(stat & stat_ie);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat != '0));
  assert_run_flag_on_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_RUN_HI]) |-> $past(step));
  assert_avg_flag_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_AVG_LO]) |-> $past(step));
endmodule

// File: tb/busmon_top_tb.sv
module busmon_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        act_event = 1'b0;
  logic        period_tick = 1'b0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  busmon_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_event(act_event),
    .period_tick(period_tick), .irq(irq)
  );

  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // reference average step: floor division on the signed difference
  function automatic longint ema_m(input longint a, input longint c, input int k);
    longint w;
    w = longint'(1) << (k + 1);
    if (c >= a) return a + ((c - a) / w);
    return a - ((a - c + w - 1) / w);
  endfunction

  // ie: [3] run-high, [2] run-low, [1] avg-high, [0] avg-low
  function automatic logic [31:0] mk_ctrl(input bit en, input bit per, input int k,
                                          input int nlo, input int nhi, input logic [3:0] ie);
    logic [31:0] c;
    c = '0;
    c[31]    = en;
    c[18]    = per;
    c[12:10] = k[2:0];
    c[25:23] = nlo[2:0];
    c[28:26] = nhi[2:0];
    c[30]    = ie[3];
    c[29]    = ie[2];
    c[21]    = ie[1];
    c[20]    = ie[0];
    return c;
  endfunction

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic evts(input int n);
    if (n > 0) begin
      @(negedge clk);
      act_event = 1'b1;
      repeat (n) @(negedge clk);
      act_event = 1'b0;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    period_tick = 1'b1;
    @(negedge clk);
    period_tick = 1'b0;
  endtask

  task automatic period_chk(input string tag, input int n, input logic [31:0] mask,
                            input logic [31:0] exp);
    logic [31:0] v;
    evts(n);
    tick();
    rd(6'h24, v);
    check(tag, v & mask, exp);
  endtask

  task automatic avg_chk(input string tag, input longint exp);
    logic [31:0] v;
    rd(6'h20, v);
    check(tag, v, exp[31:0]);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    @(negedge clk);
    #1 check(tag, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(6'h00, v); check("R1 ctrl after reset", v, 0);
    rd(6'h20, v); check("R1 avg after reset", v, 0);
    rd(6'h24, v); check("R1 status after reset", v, 0);
    irq_chk("R1 irq after reset", 1'b0);
  endtask

  task automatic t_readback();
    logic [31:0] v, c;
    c = mk_ctrl(0, 1, 5, 2, 1, 4'b1010);
    wr(6'h04, 32'h1234); wr(6'h08, 32'h55); wr(6'h10, 32'hA0);
    wr(6'h14, 32'h0B);   wr(6'h18, 32'h400); wr(6'h00, c);
    wr(6'h0C, 32'h77);
    rd(6'h00, v); check("R11 ctrl", v, c);
    rd(6'h04, v); check("R11 upper", v, 32'h1234);
    rd(6'h08, v); check("R11 lower", v, 32'h55);
    rd(6'h10, v); check("R11 avg high limit", v, 32'hA0);
    rd(6'h14, v); check("R11 avg low limit", v, 32'h0B);
    rd(6'h18, v); check("R11 weight", v, 32'h400);
    rd(6'h1C, v); check("R11 unmapped", v, 0);
    rd(6'h0C, v); check("R11 seed", v, 32'h77);
    rd(6'h20, v); check("R5 seed loads avg", v, 32'h77);
  endtask

  task automatic t_ema();
    logic [31:0] v;
    wr(6'h18, 100); wr(6'h04, ONES); wr(6'h08, 0);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    wr(6'h0C, 100);
    evts(3); tick(); avg_chk("R4 avg rises k0", ema_m(100, 300, 0));
    tick();          avg_chk("R4 avg falls k0", ema_m(200, 0, 0));
    wr(6'h0C, 101);
    tick();          avg_chk("R4 odd negative floors", ema_m(101, 0, 0));
    wr(6'h00, mk_ctrl(1, 1, 2, 0, 0, 0));
    wr(6'h0C, 0);
    evts(8); tick(); avg_chk("R4 window 8", ema_m(0, 800, 2));
    wr(6'h0C, 500);
    evts(2);
    @(negedge clk);
    period_tick = 1'b1; reg_wen = 1'b1; reg_addr = 6'h0C; reg_wdata = 300;
    @(negedge clk);
    period_tick = 1'b0; reg_wen = 1'b0;
    rd(6'h20, v); check("R5 seed wins over close", v, 300);
  endtask

  task automatic t_ignored();
    wr(6'h18, 100);
    wr(6'h00, mk_ctrl(1, 0, 0, 0, 0, 0));
    wr(6'h0C, 40);
    evts(2); tick(); avg_chk("R3 tick ignored without periodic", 40);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    tick();          avg_chk("R3 count kept across ignored tick", ema_m(40, 200, 0));
    wr(6'h00, mk_ctrl(0, 1, 0, 0, 0, 0));
    tick();          avg_chk("R3 tick ignored while disabled", 120);
    evts(3);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    tick();          avg_chk("R3 events ignored while disabled", ema_m(120, 0, 0));
    @(negedge clk);
    act_event = 1'b1; period_tick = 1'b1;
    @(negedge clk);
    act_event = 1'b0; period_tick = 1'b0;
    avg_chk("R3 closing-cycle event excluded", ema_m(60, 0, 0));
    tick();          avg_chk("R3 closing-cycle event in next period", ema_m(30, 100, 0));
  endtask

  task automatic t_run_high();
    int seq1 [6] = '{6, 6, 0, 6, 6, 6};
    bit exp1 [6] = '{0, 0, 0, 0, 0, 1};
    wr(6'h04, 500); wr(6'h08, 0); wr(6'h18, 100);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 2, 0));
    wr(6'h24, ONES);
    foreach (seq1[i])
      period_chk("R6 high run", seq1[i], 32'h8000_0000, exp1[i] ? 32'h8000_0000 : 0);
    wr(6'h24, 32'h8000_0000);
    period_chk("R6 restart 1", 6, 32'h8000_0000, 0);
    period_chk("R6 restart 2", 6, 32'h8000_0000, 0);
    period_chk("R6 restart 3", 6, 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_run_low();
    wr(6'h04, ONES); wr(6'h08, 50); wr(6'h18, 100);
    wr(6'h00, mk_ctrl(1, 1, 0, 1, 0, 0));
    wr(6'h24, ONES);
    period_chk("R7 low 1", 0, 32'h4000_0000, 0);
    period_chk("R7 broken by busy period", 1, 32'h4000_0000, 0);
    period_chk("R7 low again 1", 0, 32'h4000_0000, 0);
    period_chk("R7 low again 2", 0, 32'h4000_0000, 32'h4000_0000);
    wr(6'h24, 32'h4000_0000);
    period_chk("R7 restart 1", 0, 32'h4000_0000, 0);
    period_chk("R7 restart 2", 0, 32'h4000_0000, 32'h4000_0000);
  endtask

  task automatic t_avg_limits();
    wr(6'h04, ONES); wr(6'h08, 0); wr(6'h18, 100);
    wr(6'h10, 300); wr(6'h14, 100);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    wr(6'h0C, 200); wr(6'h24, ONES);
    period_chk("R8 avg at low limit", 0, 32'h3000_0000, 0);
    period_chk("R8 avg below low limit", 0, 32'h3000_0000, 32'h1000_0000);
    wr(6'h24, ONES); wr(6'h0C, 200);
    period_chk("R8 avg above high limit", 6, 32'h3000_0000, 32'h2000_0000);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(6'h24, 32'h1000_0000);
    rd(6'h24, v); check("R9 other bit kept", v & 32'h3000_0000, 32'h2000_0000);
    wr(6'h24, 32'h2000_0000);
    rd(6'h24, v); check("R9 written bit cleared", v & 32'h3000_0000, 0);
    wr(6'h04, 0); wr(6'h10, ONES); wr(6'h14, 0);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    evts(1);
    @(negedge clk);
    period_tick = 1'b1; reg_wen = 1'b1; reg_addr = 6'h24; reg_wdata = ONES;
    @(negedge clk);
    period_tick = 1'b0; reg_wen = 1'b0;
    rd(6'h24, v); check("R9 set wins over clear", v & 32'h8000_0000, 32'h8000_0000);
  endtask

  task automatic t_irq();
    wr(6'h04, ONES); wr(6'h24, ONES);
    wr(6'h04, 0); wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    evts(1); tick();
    wr(6'h04, ONES);
    irq_chk("R10 flag masked", 1'b0);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 4'b1000));
    irq_chk("R10 run-high enabled", 1'b1);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 4'b0111));
    irq_chk("R10 other enables only", 1'b0);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 4'b1111));
    wr(6'h24, ONES);
    irq_chk("R10 cleared", 1'b0);
    wr(6'h14, 1000); wr(6'h0C, 0);
    tick();
    irq_chk("R10 avg-low flag", 1'b1);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 4'b0010));
    irq_chk("R10 avg-low masked", 1'b0);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 4'b0001));
    irq_chk("R10 avg-low enabled", 1'b1);
  endtask

  task automatic t_saturate();
    wr(6'h04, 32'hFFFF_FFFE); wr(6'h08, 0); wr(6'h10, ONES); wr(6'h14, 0);
    wr(6'h00, mk_ctrl(1, 1, 0, 0, 0, 0));
    wr(6'h0C, 0); wr(6'h18, 32'hC000_0000); wr(6'h24, ONES);
    period_chk("R2 one pulse below upper", 1, 32'h8000_0000, 0);
    wr(6'h0C, 0); wr(6'h24, ONES);
    period_chk("R2 saturated count breaches", 2, 32'h8000_0000, 32'h8000_0000);
    avg_chk("R2 saturated count into avg", ema_m(0, 64'hFFFF_FFFF, 0));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_ema();
    t_ignored();
    t_run_high();
    t_run_low();
    t_avg_limits();
    t_w1c();
    t_irq();
    t_saturate();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule